// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes one load from a group of 32 lanes in a single handshake. Each lane has a valid bit and a word address. Memory is divided into aligned four-word burst sections. The block issues one memory request for each distinct section that the active lanes touch, rather than one request per lane. When a burst comes back, every waiting lane whose word falls in that section picks up its own word from the burst.

A warp whose active lanes all fall in one section costs a single transaction. Scattered or strided lanes cost up to 32. The block reports the number of transactions it used, and signals completion with a one-cycle pulse. The per-lane results stay on the outputs until the next warp is accepted.

Top module: `warp_coalescer`

## Requirements
- R1: During and straight after reset, `reqReady` is 1, `memReqValid` is 0, `done` is 0, `txnCount` is 0 and `laneHit` is all zero.
- R2: Each memory request carries a word address whose two low bits are zero (section base = lane address with its two low bits cleared). The response holds four words, and word k sits in bits [32k+31:32k]. Each active lane receives the word selected by the two low bits of its own address.
- R3: If every active lane's address falls in the same section, exactly one memory request is issued and `txnCount` ends at 1.
- R4: Otherwise there is one request per distinct section touched, and `txnCount` ends equal to the number of distinct sections (at most 32).
- R5: Sections are requested in ascending order of the lowest-numbered lane that touches each one. A section touched by non-adjacent lanes is still requested only once.
- R6: A lane whose valid bit is low takes no part in grouping. Its `laneHit` bit stays 0 and its `laneData` stays 0.
- R7: `done` is high for exactly one cycle, in the cycle right after the cycle in which the last burst was taken. After that, `laneData`, `laneHit` and `txnCount` stay unchanged until the next warp is accepted. Accepting a warp clears `laneData` and `laneHit`.
- R8: While `memReqValid` is high and `memReqReady` is low, the request stays valid with the same address. No section is lost or issued twice.
- R9: A warp with no valid lanes issues no memory request. It gives `done` in the cycle after it is accepted, with `txnCount` equal to 0.
- R10: Only one memory request is outstanding at a time. `memReqValid` is low while a burst is awaited and while `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Warp load request present |
| reqReady | output | 1 | Block is idle and will accept a warp |
| laneValid | input | 32 | Per-lane valid bits |
| laneAddr | input | 512 | Per-lane word addresses, 16 bits each; lane i in bits [16i+15:16i] |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 16 | Aligned section base word address |
| memRespValid | input | 1 | Burst data present (one cycle per request) |
| memRespData | input | 128 | Four-word burst; word k in bits [32k+31:32k] |
| laneData | output | 1024 | Per-lane returned words; lane i in bits [32i+31:32i] |
| laneHit | output | 32 | Lanes that have received data for the current warp |
| done | output | 1 | One-cycle completion pulse |
| txnCount | output | 6 | Memory requests used by the current warp |

## Verification
The properties assume that the memory side returns exactly one burst per accepted request, as a single-cycle `memRespValid` pulse. They also assume that this pulse arrives only while a request is outstanding, and that `reqValid` is not raised again during the `done` cycle unless a new warp is intended. The bench memory model raises a response only after it has logged a request handshake, after a random delay of zero to two cycles, and never twice for the same request. It drives `memReqReady` either always high or randomly low to create back-pressure. Warps are launched only while the block is idle, and inputs are held quiet while the outputs are checked for stability.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic latch;      // capture a new warp
    logic issueFire;  // a section request was accepted by memory
    logic respFire;   // a burst is being taken
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } coalState_t;

endpackage

// File: rtl/coalesce_dpath.sv
module coalesce_dpath
  import coalesce_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BURST_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctrlStrobe_t                   strobe,
  input  logic [LANES-1:0]              laneValidIn,
  input  logic [LANES*ADDR_W-1:0]       laneAddrIn,
  input  logic [BURST_WORDS*DATA_W-1:0] memRespData,
  output logic [ADDR_W-1:0]             memReqAddr,
  output logic                          inAny,
  output logic                          lastResp,
  output logic [LANES*DATA_W-1:0]       laneData,
  output logic [LANES-1:0]              laneHit,
  output logic [$clog2(LANES+1)-1:0]    txnCount
);

  localparam int OFF_W = $clog2(BURST_WORDS);
  localparam int SEC_W = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(LANES+1);
  localparam int IDX_W = $clog2(LANES);

  logic [ADDR_W-1:0] addrQ [LANES];
  logic [DATA_W-1:0] dataQ [LANES];
  logic [LANES-1:0]  pendQ;
  logic [LANES-1:0]  hitQ;
  logic [SEC_W-1:0]  curSec;
  logic [CNT_W-1:0]  cntQ;
  logic [IDX_W-1:0]  leaderIdx;
  logic [LANES-1:0]  matchMask;
  logic [DATA_W-1:0] burstWord [BURST_WORDS];

  // split the burst into words
  for (genvar k = 0; k < BURST_WORDS; k++) begin : g_word
    assign burstWord[k] = memRespData[k*DATA_W +: DATA_W];
  end

  // lanes still waiting whose section matches the one in flight
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign matchMask[g] = pendQ[g] && (addrQ[g][ADDR_W-1:OFF_W] == curSec);
    assign laneData[g*DATA_W +: DATA_W] = dataQ[g];
  end

  // lowest-numbered pending lane picks the next section
  always_comb begin
    leaderIdx = '0;
    for (int i = LANES-1; i >= 0; i--) begin
      if (pendQ[i]) leaderIdx = IDX_W'(i);
    end
  end

  assign memReqAddr = {addrQ[leaderIdx][ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign inAny      = |laneValidIn;
  assign lastResp   = ((pendQ & ~matchMask) == '0);
  assign laneHit    = hitQ;
  assign txnCount   = cntQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendQ  <= '0;
      hitQ   <= '0;
      cntQ   <= '0;
      curSec <= '0;
      for (int i = 0; i < LANES; i++) begin
        addrQ[i] <= '0;
        dataQ[i] <= '0;
      end
    end else begin
      if (strobe.latch) begin
        pendQ <= laneValidIn;
        hitQ  <= '0;
        cntQ  <= '0;
        for (int i = 0; i < LANES; i++) begin
          addrQ[i] <= laneAddrIn[i*ADDR_W +: ADDR_W];
          dataQ[i] <= '0;
        end
      end
      if (strobe.issueFire) begin
        curSec <= addrQ[leaderIdx][ADDR_W-1:OFF_W];
        cntQ   <= cntQ + 1'b1;
      end
      if (strobe.respFire) begin
        for (int i = 0; i < LANES; i++) begin
          if (matchMask[i]) begin
            dataQ[i] <= burstWord[addrQ[i][OFF_W-1:0]];
            hitQ[i]  <= 1'b1;
            pendQ[i] <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/coalesce_ctrl.sv
module coalesce_ctrl
  import coalesce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        inAny,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  logic        lastResp,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        done
);

  coalState_t state, stateNext;
  logic       doneQ, doneNext;

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    doneNext    = 1'b0;
    reqReady    = (state == ST_IDLE);
    memReqValid = (state == ST_ISSUE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latch = 1'b1;
          if (inAny) stateNext = ST_ISSUE;
          else       doneNext  = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (memReqReady) begin
          strobe.issueFire = 1'b1;
          stateNext        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (memRespValid) begin
          strobe.respFire = 1'b1;
          if (lastResp) begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end else begin
            stateNext = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= doneNext;
    end
  end

  assign done = doneQ;

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coalesce_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BURST_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [LANES-1:0]              laneValid,
  input  logic [LANES*ADDR_W-1:0]       laneAddr,
  output logic                          memReqValid,
  input  logic                          memReqReady,
  output logic [ADDR_W-1:0]             memReqAddr,
  input  logic                          memRespValid,
  input  logic [BURST_WORDS*DATA_W-1:0] memRespData,
  output logic [LANES*DATA_W-1:0]       laneData,
  output logic [LANES-1:0]              laneHit,
  output logic                          done,
  output logic [$clog2(LANES+1)-1:0]    txnCount
);

  ctrlStrobe_t strobe;
  logic        inAny;
  logic        lastResp;

  coalesce_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqValid     (reqValid),
    .inAny        (inAny),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .lastResp     (lastResp),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .done         (done)
  );

  coalesce_dpath #(
    .LANES       (LANES),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BURST_WORDS (BURST_WORDS)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .laneValidIn (laneValid),
    .laneAddrIn  (laneAddr),
    .memRespData (memRespData),
    .memReqAddr  (memReqAddr),
    .inAny       (inAny),
    .lastResp    (lastResp),
    .laneData    (laneData),
    .laneHit     (laneHit),
    .txnCount    (txnCount)
  );

endmodule

// File: rtl/warp_coalescer_checker.sv
module warp_coalescer_checker #(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BURST_WORDS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reqValid,
  input logic                       reqReady,
  input logic                       memReqValid,
  input logic                       memReqReady,
  input logic [ADDR_W-1:0]          memReqAddr,
  input logic                       memRespValid,
  input logic [LANES*DATA_W-1:0]    laneData,
  input logic                       done,
  input logic [$clog2(LANES+1)-1:0] txnCount
);

  localparam int OFF_W = $clog2(BURST_WORDS);
  localparam int CNT_W = $clog2(LANES+1);

  // R2: section requests are aligned to the burst size
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> (memReqAddr[OFF_W-1:0] == '0));

  // R8: a stalled request is held with the same address
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R4: every accepted request advances the count by one
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && memReqReady) |=> (txnCount == CNT_W'($past(txnCount) + 1'b1)));

  // R9: accepting a warp restarts the count
  a_r9_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> (txnCount == '0));

  // R10: no memory request while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !memReqValid);

  // R7: done is a single-cycle pulse unless a new warp was taken
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $past(reqValid && reqReady)));

  // R7: done follows a burst or an accepted empty warp
  a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(memRespValid) || $past(reqValid && reqReady)));

  // R7: lane data moves only on a burst or on acceptance
  a_r7_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!memRespValid && !(reqValid && reqReady)) |=> $stable(laneData));

endmodule

bind warp_coalescer warp_coalescer_checker #(
  .LANES       (LANES),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .BURST_WORDS (BURST_WORDS)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqAddr   (memReqAddr),
  .memRespValid (memRespValid),
  .laneData     (laneData),
  .done         (done),
  .txnCount     (txnCount)
);

// File: tb/warp_coalescer_test.sv
`timescale 1ns/1ps
module warp_coalescer_test;

  localparam int LANES = 32;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int BW    = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                reqValid = 1'b0;
  logic                reqReady;
  logic [LANES-1:0]    laneValid = '0;
  logic [LANES*AW-1:0] laneAddr = '0;
  logic                memReqValid;
  logic                memReqReady = 1'b1;
  logic [AW-1:0]       memReqAddr;
  logic                memRespValid = 1'b0;
  logic [BW*DW-1:0]    memRespData = '0;
  logic [LANES*DW-1:0] laneData;
  logic [LANES-1:0]    laneHit;
  logic                done;
  logic [5:0]          txnCount;

  warp_coalescer uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .laneValid(laneValid), .laneAddr(laneAddr), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRespValid(memRespValid),
    .memRespData(memRespData), .laneData(laneData), .laneHit(laneHit),
    .done(done), .txnCount(txnCount)
  );

  always #2 clk = ~clk;  // 250 MHz

  int nChecks = 0;
  int nFails  = 0;

  int wAddr [LANES];
  bit wValid [LANES];
  bit stallMode = 0;
  int logAddr [64];
  int logN = 0;
  bit r10Bad = 0;

  function automatic logic [31:0] memWord(input int a);
    return 32'h5A00_1234 ^ (a * 32'h0001_0003);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // burst-returning memory with optional back-pressure
  initial begin
    bit     waiting = 0;
    int     cnt = 0;
    int     pendA = 0;
    bit     prevStall = 0;
    int     prevAddr = 0;
    forever begin
      bit hs;
      int a;
      @(posedge clk);
      hs = memReqValid && memReqReady;
      a  = int'(memReqAddr);
      if (rst_n && prevStall) begin
        // R8: stalled request must be held unchanged
        chk(memReqValid && (a == prevAddr), "R8 hold", longint'(a), longint'(prevAddr));
      end
      if (rst_n && waiting && memReqValid) r10Bad = 1;  // R10
      prevStall = memReqValid && !memReqReady;
      prevAddr  = a;
      #1;
      memRespValid = 1'b0;
      if (hs) begin
        if (logN < 64) logAddr[logN] = a;
        logN++;
        waiting = 1;
        pendA   = a;
        cnt     = $urandom % 3;
      end else if (waiting) begin
        if (cnt == 0) begin
          memRespValid = 1'b1;
          for (int k = 0; k < BW; k++) memRespData[k*DW +: DW] = memWord(pendA + k);
          waiting = 0;
        end else begin
          cnt--;
        end
      end
      memReqReady = stallMode ? (($urandom % 3) == 0) : 1'b1;
    end
  end

  task automatic runWarp(input string name);
    int expSec [LANES];
    int expN = 0;
    int iters = 0;
    bit prevResp = 0;
    logic [LANES*DW-1:0] snap;
    for (int i = 0; i < LANES; i++) begin
      if (wValid[i]) begin
        bit seen = 0;
        for (int k = 0; k < expN; k++) if (expSec[k] == wAddr[i] / 4) seen = 1;
        if (!seen) begin
          expSec[expN] = wAddr[i] / 4;
          expN++;
        end
      end
    end
    for (int i = 0; i < LANES; i++) begin
      laneValid[i] = wValid[i];
      laneAddr[i*AW +: AW] = AW'(wAddr[i]);
    end
    logN = 0;
    r10Bad = 0;
    reqValid = 1'b1;
    do @(posedge clk); while (!reqReady);
    #1 reqValid = 1'b0;
    forever begin
      @(posedge clk);
      iters++;
      if (done) break;
      prevResp = memRespValid;
    end
    #1;
    if (expN == 0) begin
      chk(iters == 1 && logN == 0 && txnCount == 6'd0, {"R9 empty warp ", name},
          longint'(logN), 0);
    end else begin
      chk(prevResp, {"R7 done after last burst ", name}, longint'(prevResp), 1);
      chk(int'(txnCount) == expN, {(expN == 1) ? "R3 count " : "R4 count ", name},
          longint'(txnCount), longint'(expN));
      chk(logN == expN, {"R8 no lost/duplicate request ", name}, longint'(logN), longint'(expN));
      for (int k = 0; k < expN && k < logN; k++)
        chk(logAddr[k] == expSec[k] * 4, {"R5 order ", name},
            longint'(logAddr[k]), longint'(expSec[k] * 4));
    end
    chk(!r10Bad, {"R10 single outstanding ", name}, longint'(r10Bad), 0);
    for (int i = 0; i < LANES; i++) begin
      if (wValid[i]) begin
        chk(laneHit[i] && laneData[i*DW +: DW] == memWord(wAddr[i]), {"R2 lane data ", name},
            longint'(laneData[i*DW +: DW]), longint'(memWord(wAddr[i])));
      end else begin
        chk(!laneHit[i] && laneData[i*DW +: DW] == '0, {"R6 inactive lane ", name},
            longint'(laneData[i*DW +: DW]), 0);
      end
    end
    snap = laneData;
    repeat (3) @(posedge clk);
    #1;
    chk(laneData == snap && !done && int'(txnCount) == expN, {"R7 held outputs ", name},
        longint'(done), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(reqReady && !memReqValid && !done && txnCount == 6'd0 && laneHit == '0,
        "R1 reset state", longint'(txnCount), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(reqReady && !memReqValid && !done, "R1 after reset", longint'(reqReady), 1);

    // R3: all lanes in one section
    for (int i = 0; i < LANES; i++) begin wValid[i] = 1; wAddr[i] = 40 + (i % 4); end
    runWarp("same section");
    // R4: consecutive words span eight sections
    for (int i = 0; i < LANES; i++) begin wValid[i] = 1; wAddr[i] = i; end
    runWarp("consecutive");
    // R4: stride of one section per lane
    for (int i = 0; i < LANES; i++) begin wValid[i] = 1; wAddr[i] = i * 4; end
    runWarp("strided");
    // R5: interleaved, non-adjacent lanes share sections
    for (int i = 0; i < LANES; i++) begin wValid[i] = 1; wAddr[i] = (i % 2 == 0) ? 100 + (i % 4) : 9; end
    runWarp("interleaved");
    // R6: sparse valid mask
    for (int i = 0; i < LANES; i++) begin wValid[i] = (i % 3 == 0); wAddr[i] = 200 + i * 3; end
    runWarp("sparse");
    // R9: empty warp
    for (int i = 0; i < LANES; i++) begin wValid[i] = 0; wAddr[i] = i; end
    runWarp("empty");
    // single top lane
    for (int i = 0; i < LANES; i++) begin wValid[i] = (i == 31); wAddr[i] = 77; end
    runWarp("top lane only");
    // R8: strided under back-pressure
    stallMode = 1;
    for (int i = 0; i < LANES; i++) begin wValid[i] = 1; wAddr[i] = 1000 - i * 4; end
    runWarp("strided stalled");

    for (int n = 0; n < 40; n++) begin
      int base = ($urandom % 60) * 4;
      bit oneSec = (($urandom % 4) == 0);
      stallMode = $urandom % 2;
      for (int i = 0; i < LANES; i++) begin
        wValid[i] = (($urandom % 4) != 0);
        wAddr[i]  = oneSec ? base + ($urandom % 4) : int'($urandom % 96);
      end
      runWarp("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule